// File: doc/BRIEF.md
# Watchdog Key-Guarded Register Bank

This block is the register bank between a host bus and the counting core of a watchdog timer. It holds three 8-bit registers: a count register, a control register and a reset-status register. The reset-status register contains an overflow flag and a reset-enable bit. Two write offsets are shared by these registers. A write selects its target through a key byte carried in the upper half of a 16-bit word transfer. A stray write therefore cannot easily change the watchdog.

The counting core receives the count value, the control byte, the overflow flag and the reset-enable bit on plain output pins. It receives a one-cycle load strobe whenever the host rewrites the count. The core reports an overflow on a one-cycle event input, and that event sets the overflow flag. The host reads back the registers with byte transfers. Read data appears one clock after the read strobe and holds until the next read. The bus is a single-cycle register port with no back-pressure, so the block has no valid/ready pair. A strobe is accepted in the cycle it is high.

Top module: `wdt_keyreg`

## Requirements
- R1: A word write at offset 0 with upper byte 0x5A loads the lower byte into the count register. In the cycle after the write edge, `cnt_q` shows the new value and `cnt_load` is high for exactly that one cycle.
- R2: A word write at offset 0 with upper byte 0xA5 loads the lower byte into the control register (`ctl_q`). It leaves the count register unchanged and does not pulse `cnt_load`.
- R3: Byte writes (`is_word`=0) change no register at any offset. Word writes to offsets 1 and 3 change no register.
- R4: A word write at offset 2 with data 0xA500 clears the overflow flag and leaves the reset-enable bit unchanged.
- R5: A word write at offset 2 with upper byte 0x5A copies bit 6 of the lower byte into the reset-enable bit and leaves the overflow flag unchanged.
- R6: A word write at offset 0 or 2 whose upper byte is neither 0x5A nor 0xA5 changes no register. A write at offset 2 with upper byte 0xA5 and a nonzero lower byte also changes no register.
- R7: An `ovf_evt` pulse sets the overflow flag at the next edge. If a clear write (R4) arrives in the same cycle, the flag ends up set.
- R8: A read captures data into `rdata`, which is valid one cycle after `rd_en` and holds until the next read. Offset 0 returns the control register and offset 1 returns the count. Offset 3 returns the reset-status byte: bit 7 is the overflow flag, bit 6 is reset-enable, and bits 5..0 read as 1. Offset 2 returns 0xFF.
- R9: After reset, the count and control registers are 0x00, the overflow flag and reset-enable are 0, `cnt_load` is 0 and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Byte offset of the access |
| is_word | input | 1 | 1 = 16-bit word transfer, 0 = byte transfer |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data; upper byte is the key |
| rdata | output | 8 | Registered read data |
| ovf_evt | input | 1 | One-cycle overflow event from the counting core |
| cnt_q | output | 8 | Current count register |
| ctl_q | output | 8 | Current control register |
| ovf_flag | output | 1 | Overflow flag |
| rst_en | output | 1 | Reset-enable bit |
| cnt_load | output | 1 | One-cycle strobe after a count write |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. This applies to register updates, the overflow set, the load strobe and the read data. Once its strobes have been sampled at one edge, the driver deasserts them and pushes the expected count, control, flag, enable, load-strobe and read-data values into a queue. The monitor pops these values at the following falling edge, which is half a cycle after the due edge and before any further edge can move them. A missing load strobe or a strobe that lasts too long is therefore caught at the same sample as a wrong register value.

// File: rtl/wdt_keyreg_pkg.sv
package wdt_keyreg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] KEY_LO_SEL = 8'h5A; // count / reset-enable key
  localparam logic [BYTE_W-1:0] KEY_HI_SEL = 8'hA5; // control / flag-clear key

  typedef enum logic [2:0] {
    WK_NONE,
    WK_CNT,
    WK_CTL,
    WK_RSTE,
    WK_OVFCLR
  } wr_kind_e;
endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
  import wdt_keyreg_pkg::*;
#(
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter int OFF_MAIN = 0,
  parameter int OFF_RST  = 2
) (
  input  logic            wr_en,
  input  logic            is_word,
  input  logic [AW-1:0]   addr,
  input  logic [2*DW-1:0] wdata,
  output wr_kind_e        kind
);
  localparam logic [AW-1:0] A_MAIN = AW'(OFF_MAIN);
  localparam logic [AW-1:0] A_RST  = AW'(OFF_RST);

  logic [DW-1:0] key;
  logic [DW-1:0] lo;
  assign key = wdata[2*DW-1:DW];
  assign lo  = wdata[DW-1:0];

  always_comb begin
    kind = WK_NONE;
    if (wr_en && is_word) begin
      if (addr == A_MAIN) begin
        if (key == KEY_LO_SEL)      kind = WK_CNT;
        else if (key == KEY_HI_SEL) kind = WK_CTL;
      end else if (addr == A_RST) begin
        if (key == KEY_LO_SEL)                    kind = WK_RSTE;
        else if (key == KEY_HI_SEL && lo == '0)   kind = WK_OVFCLR;
      end
    end
  end
endmodule

// File: rtl/wdt_reg_core.sv
module wdt_reg_core
  import wdt_keyreg_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RSTE_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_kind_e      kind,
  input  logic [DW-1:0] lo,
  input  logic          ovf_evt,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] ctl_q,
  output logic          ovf_q,
  output logic          rste_q,
  output logic          load_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctl_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= (kind == WK_CNT);
      if (kind == WK_CNT) cnt_q <= lo;
      if (kind == WK_CTL) ctl_q <= lo;
    end
  end

  // Flag: an event set takes priority over a keyed clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (ovf_evt)            ovf_q <= 1'b1;
    else if (kind == WK_OVFCLR)  ovf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rste_q <= 1'b0;
    else if (kind == WK_RSTE)  rste_q <= lo[RSTE_BIT];
  end
endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int OFF_CTL  = 0,
  parameter int OFF_CNT  = 1,
  parameter int OFF_STAT = 3,
  parameter int OVF_BIT  = 7,
  parameter int RSTE_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] ctl,
  input  logic          ovf,
  input  logic          rste,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] stat_byte;
  logic [DW-1:0] sel;

  for (genvar b = 0; b < DW; b++) begin : g_stat
    if (b == OVF_BIT) begin : g_ovf
      assign stat_byte[b] = ovf;
    end else if (b == RSTE_BIT) begin : g_rste
      assign stat_byte[b] = rste;
    end else begin : g_fill
      assign stat_byte[b] = 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      AW'(OFF_CTL):  sel = ctl;
      AW'(OFF_CNT):  sel = cnt;
      AW'(OFF_STAT): sel = stat_byte;
      default:       sel = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/wdt_keyreg.sv
module wdt_keyreg
  import wdt_keyreg_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            is_word,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2*DW-1:0] wdata,
  output logic [DW-1:0]   rdata,
  input  logic            ovf_evt,
  output logic [DW-1:0]   cnt_q,
  output logic [DW-1:0]   ctl_q,
  output logic            ovf_flag,
  output logic            rst_en,
  output logic            cnt_load
);
  wr_kind_e kind;

  wdt_key_decode #(.AW(AW), .DW(DW), .OFF_MAIN(0), .OFF_RST(2)) u_dec (
    .wr_en(wr_en), .is_word(is_word), .addr(addr), .wdata(wdata), .kind(kind)
  );

  wdt_reg_core #(.DW(DW), .RSTE_BIT(6)) u_core (
    .clk(clk), .rst_n(rst_n), .kind(kind), .lo(wdata[DW-1:0]),
    .ovf_evt(ovf_evt), .cnt_q(cnt_q), .ctl_q(ctl_q),
    .ovf_q(ovf_flag), .rste_q(rst_en), .load_q(cnt_load)
  );

  wdt_read_mux #(.AW(AW), .DW(DW), .OFF_CTL(0), .OFF_CNT(1), .OFF_STAT(3),
                 .OVF_BIT(7), .RSTE_BIT(6)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .cnt(cnt_q), .ctl(ctl_q), .ovf(ovf_flag), .rste(rst_en), .rdata(rdata)
  );
endmodule

// File: rtl/wdt_keyreg_chk.sv
module wdt_keyreg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        is_word,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] wdata,
  input logic [7:0]  rdata,
  input logic        ovf_evt,
  input logic [7:0]  cnt_q,
  input logic [7:0]  ctl_q,
  input logic        ovf_flag,
  input logic        rst_en,
  input logic        cnt_load
);
  logic wr_word;
  assign wr_word = wr_en && is_word;

  a_r1_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && addr == 2'd0 && wdata[15:8] == 8'h5A)
      |=> (cnt_load && cnt_q == $past(wdata[7:0])));

  a_r1_load_source: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> $past(wr_word && addr == 2'd0 && wdata[15:8] == 8'h5A));

  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && addr == 2'd0 && wdata[15:8] == 8'hA5)
      |=> (!cnt_load && ctl_q == $past(wdata[7:0]) && $stable(cnt_q)));

  a_r3_byte_write_void: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_word && !ovf_evt)
      |=> ($stable(cnt_q) && $stable(ctl_q) && $stable(rst_en) && $stable(ovf_flag)));

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && addr == 2'd2 && wdata == 16'hA500 && !ovf_evt)
      |=> (!ovf_flag && $stable(rst_en)));

  a_r5_rste_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && addr == 2'd2 && wdata[15:8] == 8'h5A && !ovf_evt)
      |=> (rst_en == $past(wdata[6]) && $stable(ovf_flag)));

  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind wdt_keyreg wdt_keyreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .is_word(is_word), .wr_en(wr_en),
  .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .ovf_evt(ovf_evt),
  .cnt_q(cnt_q), .ctl_q(ctl_q), .ovf_flag(ovf_flag), .rst_en(rst_en),
  .cnt_load(cnt_load)
);

// File: tb/sim_wdt_keyreg.sv
`timescale 1ns/1ps
module sim_wdt_keyreg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        is_word = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        ovf_evt = 1'b0;
  logic [7:0]  rdata, cnt_q, ctl_q;
  logic        ovf_flag, rst_en, cnt_load;

  always #5 clk = ~clk;

  wdt_keyreg u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .is_word(is_word), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .ovf_evt(ovf_evt),
    .cnt_q(cnt_q), .ctl_q(ctl_q), .ovf_flag(ovf_flag), .rst_en(rst_en),
    .cnt_load(cnt_load)
  );

  typedef struct {
    int       req;
    int       sel;   // 0 cnt,1 ctl,2 ovf,3 rste,4 load,5 rdata
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model state, built from the requirements.
  logic [7:0] m_cnt = 8'h00, m_ctl = 8'h00, m_rd = 8'h00;
  logic       m_ovf = 1'b0, m_rste = 1'b0, m_ld = 1'b0;

  function automatic void push_all(int req);
    q.push_back('{req, 0, m_cnt});
    q.push_back('{req, 1, m_ctl});
    q.push_back('{req, 2, {7'd0, m_ovf}});
    q.push_back('{req, 3, {7'd0, m_rste}});
    q.push_back('{req, 4, {7'd0, m_ld}});
    q.push_back('{req, 5, m_rd});
  endfunction

  task automatic op(input bit w, input bit r, input bit wd, input logic [1:0] a,
                    input logic [15:0] d, input bit e, input int req);
    @(negedge clk);
    wr_en = w; rd_en = r; is_word = wd; addr = a; wdata = d; ovf_evt = e;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; ovf_evt = 1'b0;
    m_ld = 1'b0;
    if (w && wd) begin
      if (a == 2'd0 && d[15:8] == 8'h5A) begin m_cnt = d[7:0]; m_ld = 1'b1; end
      else if (a == 2'd0 && d[15:8] == 8'hA5) m_ctl = d[7:0];
      else if (a == 2'd2 && d[15:8] == 8'h5A) m_rste = d[6];
      else if (a == 2'd2 && d == 16'hA500) m_ovf = 1'b0;
    end
    if (e) m_ovf = 1'b1;
    if (r) begin
      case (a)
        2'd0: m_rd = m_ctl;
        2'd1: m_rd = m_cnt;
        2'd3: m_rd = {m_ovf, m_rste, 6'b111111};
        default: m_rd = 8'hFF;
      endcase
    end
    push_all(req);
  endtask

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = cnt_q;
          1: act = ctl_q;
          2: act = {7'd0, ovf_flag};
          3: act = {7'd0, rst_en};
          4: act = {7'd0, cnt_load};
          default: act = rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL R%0d output %0d actual %h expected %h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    push_all(9);                                      // R9 reset state
    op(1, 0, 1, 2'd0, 16'h5A3C, 0, 1);               // R1 count write
    op(0, 0, 0, 2'd0, 16'h0000, 0, 1);               // R1 strobe falls
    op(1, 0, 1, 2'd0, 16'hA581, 0, 2);               // R2 control write
    op(0, 1, 0, 2'd0, 16'h0000, 0, 8);               // R8 read control
    op(0, 1, 0, 2'd1, 16'h0000, 0, 8);               // R8 read count
    op(1, 0, 0, 2'd0, 16'h5A77, 0, 3);               // R3 byte write ignored
    op(1, 0, 1, 2'd1, 16'h5A11, 0, 3);               // R3 word at offset 1
    op(1, 0, 1, 2'd3, 16'h5A40, 0, 3);               // R3 word at offset 3
    op(1, 0, 1, 2'd0, 16'h5522, 0, 6);               // R6 bad key
    op(0, 0, 0, 2'd0, 16'h0000, 1, 7);               // R7 event sets flag
    op(1, 0, 1, 2'd2, 16'hA501, 0, 6);               // R6 A5 with nonzero low
    op(1, 0, 0, 2'd2, 16'hA500, 0, 3);               // R3 byte clear ignored
    op(0, 1, 0, 2'd3, 16'h0000, 0, 8);               // R8 status = 0xBF
    op(1, 0, 1, 2'd2, 16'h5A40, 0, 5);               // R5 set reset-enable
    op(0, 1, 0, 2'd3, 16'h0000, 0, 8);               // R8 status = 0xFF
    op(1, 0, 1, 2'd2, 16'hA500, 0, 4);               // R4 clear flag
    op(0, 1, 0, 2'd2, 16'h0000, 0, 8);               // R8 offset 2 reads 0xFF
    op(0, 1, 0, 2'd3, 16'h0000, 0, 8);               // R8 status = 0x7F
    op(1, 0, 1, 2'd2, 16'hA500, 1, 7);               // R7 set beats clear
    op(1, 0, 1, 2'd2, 16'h5ABF, 0, 5);               // R5 bit6=0 clears enable
    op(1, 0, 1, 2'd0, 16'h5A00, 0, 1);               // R1 load zero
    op(0, 0, 0, 2'd0, 16'h0000, 0, 8);               // R8 rdata holds
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule